// File: doc/BRIEF.md
# Configuration Request Engine

This block turns a handful of software-written registers into one single-DW Type 0 configuration request toward a link-layer model. Software fills three header words and a data word through a simple register bus. It then sets a go bit, and the engine presents the whole header plus data on an outbound request port. The engine holds that request until it is accepted, and then waits for the matching completion.

When the completion arrives, the go bit drops by itself and the 3-bit completion status is latched next to it in the same control word. For a read request that completes cleanly, the returned DW is stored in a read-data register. The full DW is kept, and software picks out the bytes it wants using the low offset bits. If no completion comes within a parameterised number of cycles, the engine abandons the request and reports an abort status.

Software owns the header layout:
- **Header word 0:** length in bits 9:0, type in bits 28:24, and format in bits 31:29.
- **Header word 1:** byte enables.
- **Header word 2:** register number, function, device and bus.
- **Write data:** placed in its byte lane before it is written.

The engine copies all four words unchanged. It decodes only the format field.

Top module: `cfg_req_engine`

## Requirements
- R1: After reset, every readable register reads 0, the go bit is 0, the status is 0 and `req_valid` is 0.
- R2: The header words at offsets 0x460, 0x464 and 0x468 and the write-data word at 0x470 read back exactly what was last written. `reg_rdata` shows the register at `reg_addr` one clock after the address is presented.
- R3: Writing a 1 in bit 0 of the control word at 0x488 while idle starts a request. From the next cycle, bit 0 reads 1, status bits 7:5 read 0, and `req_valid` is high. At that point `req_hdr0`, `req_hdr1`, `req_hdr2` and `req_data` equal the four words as they stood when the go bit was written.
- R4: `req_valid` stays high with unchanged contents until a cycle with `req_ready` high. It then drops, and exactly one request is accepted per start.
- R5: A start written while a request is pending has no effect: no new request is issued and the control word is unchanged.
- R6: A completion (`cpl_valid`) arriving after the request was accepted clears bit 0 and latches `cpl_status` into bits 7:5. A nonzero status means the request failed.
- R7: The read-data register at 0x48C takes `cpl_data` only for a completion with status 0 to a request whose format field (header word 0 bits 31:29) was 0, which means a read. Other completions leave it unchanged.
- R8: If no completion arrives within `TIMEOUT_CYCLES` clocks of the start, bit 0 clears, `req_valid` drops and bits 7:5 read 3'b111.
- R9: `cpl_valid` while no accepted request is outstanding is ignored.
- R10: Writes to 0x48C, and writes to 0x488 with bit 0 clear, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| req_valid | output | 1 | Outbound request present |
| req_ready | input | 1 | Link model accepts request |
| req_hdr0 | output | 32 | Header word 0 |
| req_hdr1 | output | 32 | Header word 1 (byte enables) |
| req_hdr2 | output | 32 | Header word 2 (target and register) |
| req_data | output | 32 | Write payload, lane-aligned |
| cpl_valid | input | 1 | Completion arrives |
| cpl_status | input | 3 | Completion status, 0 is success |
| cpl_data | input | 32 | Completion payload |

## Verification
The assertions check the outbound handshake on every cycle:
- a request that is not accepted stays valid with stable contents;
- acceptance drops valid for good;
- valid never appears without a pending request;
- a new start always clears the status;
- a drop of the pending flag without a completion leaves the abort code;
- the read-data register changes only on a clean read completion.

Only the bench scenarios can show the rest. That covers which header values are issued, that a second start or a stray completion does nothing, and that write and failed completions leave the read data alone. It also covers the exact cycle the timeout fires, all compared against a behavioural model every clock.

// File: rtl/cfg_eng_pkg.sv
package cfg_eng_pkg;
  localparam int DW     = 32;
  localparam int STAT_W = 3;
  localparam int NWORDS = 4;

  localparam logic [11:0] OFF_HDR0 = 12'h460;
  localparam logic [11:0] OFF_HDR1 = 12'h464;
  localparam logic [11:0] OFF_HDR2 = 12'h468;
  localparam logic [11:0] OFF_WDAT = 12'h470;
  localparam logic [11:0] OFF_CTRL = 12'h488;
  localparam logic [11:0] OFF_RDAT = 12'h48C;

  localparam int GO_BIT  = 0;
  localparam int ST_LSB  = 5;
  localparam int FMT_LSB = 29;

  localparam logic [STAT_W-1:0] ST_OK    = 3'b000;
  localparam logic [STAT_W-1:0] ST_ABORT = 3'b111;
  localparam logic [2:0]        FMT_READ = 3'd0;

  function automatic logic [11:0] word_off(input int idx);
    case (idx)
      0:       return OFF_HDR0;
      1:       return OFF_HDR1;
      2:       return OFF_HDR2;
      default: return OFF_WDAT;
    endcase
  endfunction
endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_eng_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DW-1:0]            wdata,
  input  logic                     busy,
  input  logic [STAT_W-1:0]        status,
  input  logic                     rd_capture,
  input  logic [DW-1:0]            cpl_data,
  output logic [NWORDS-1:0][DW-1:0] words,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] rd_q;
  logic [DW-1:0] ctrl_view;

  genvar gi;
  generate
    for (gi = 0; gi < NWORDS; gi++) begin : g_word
      localparam logic [ADDR_W-1:0] MY_OFF = ADDR_W'(word_off(gi));
      always_ff @(posedge clk) begin
        if (rst)                       words[gi] <= '0;
        else if (we && addr == MY_OFF) words[gi] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)             rd_q <= '0;
    else if (rd_capture) rd_q <= cpl_data;
  end

  always_comb begin
    ctrl_view                          = '0;
    ctrl_view[GO_BIT]                  = busy;
    ctrl_view[ST_LSB +: STAT_W]        = status;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      unique case (addr)
        ADDR_W'(OFF_HDR0): rdata <= words[0];
        ADDR_W'(OFF_HDR1): rdata <= words[1];
        ADDR_W'(OFF_HDR2): rdata <= words[2];
        ADDR_W'(OFF_WDAT): rdata <= words[3];
        ADDR_W'(OFF_CTRL): rdata <= ctrl_view;
        ADDR_W'(OFF_RDAT): rdata <= rd_q;
        default:           rdata <= '0;
      endcase
    end
  end

  // R7: read data moves only on a clean read completion
  assert_rd_update_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_q) |-> $past(rd_capture));
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_eng_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 5_000_000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      launch_wr,
  input  logic [NWORDS-1:0][DW-1:0] words,
  input  logic                      req_ready,
  input  logic                      cpl_valid,
  input  logic [STAT_W-1:0]         cpl_status,
  output logic                      busy,
  output logic [STAT_W-1:0]         status,
  output logic                      req_valid,
  output logic [NWORDS-1:0][DW-1:0] snap,
  output logic                      rd_capture
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] age;
  logic             is_read;
  logic             done;

  assign done       = busy && !req_valid && cpl_valid;
  assign rd_capture = done && is_read && (cpl_status == ST_OK);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      status    <= ST_OK;
      req_valid <= 1'b0;
      snap      <= '0;
      is_read   <= 1'b0;
      age       <= '0;
    end else if (!busy && launch_wr) begin
      busy      <= 1'b1;
      status    <= ST_OK;
      req_valid <= 1'b1;
      snap      <= words;
      is_read   <= (words[0][FMT_LSB +: 3] == FMT_READ);
      age       <= '0;
    end else if (busy) begin
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (done) begin
        busy   <= 1'b0;
        status <= cpl_status;
      end else if (age == CNT_LAST) begin
        busy      <= 1'b0;
        req_valid <= 1'b0;
        status    <= ST_ABORT;
      end else begin
        age <= age + 1'b1;
      end
    end
  end

  // R4: an unaccepted request stays up with stable contents
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && age != CNT_LAST) |=> (req_valid && $stable(snap)));
  // R4: one accepted handshake per start
  assert_single_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_valid);
  // R3: valid only while a request is pending
  assert_valid_busy_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> busy);
  // R3: a start clears the status
  assert_status_clear_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (status == ST_OK));
  // R8: pending ends without completion only by abort
  assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(cpl_valid)) |-> (status == ST_ABORT));
endmodule

// File: rtl/cfg_req_engine.sv
module cfg_req_engine
  import cfg_eng_pkg::*;
#(
  parameter int ADDR_W         = 12,
  parameter int TIMEOUT_CYCLES = 5_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [31:0]       req_hdr0,
  output logic [31:0]       req_hdr1,
  output logic [31:0]       req_hdr2,
  output logic [31:0]       req_data,
  input  logic              cpl_valid,
  input  logic [2:0]        cpl_status,
  input  logic [31:0]       cpl_data
);
  logic [NWORDS-1:0][DW-1:0] words;
  logic [NWORDS-1:0][DW-1:0] snap;
  logic                      busy;
  logic [STAT_W-1:0]         status;
  logic                      rd_capture;
  logic                      launch_wr;

  assign launch_wr = reg_we && (reg_addr == ADDR_W'(OFF_CTRL)) && reg_wdata[GO_BIT];

  cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .busy       (busy),
    .status     (status),
    .rd_capture (rd_capture),
    .cpl_data   (cpl_data),
    .words      (words),
    .rdata      (reg_rdata)
  );

  cfg_seq #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .launch_wr  (launch_wr),
    .words      (words),
    .req_ready  (req_ready),
    .cpl_valid  (cpl_valid),
    .cpl_status (cpl_status),
    .busy       (busy),
    .status     (status),
    .req_valid  (req_valid),
    .snap       (snap),
    .rd_capture (rd_capture)
  );

  assign req_hdr0 = snap[0];
  assign req_hdr1 = snap[1];
  assign req_hdr2 = snap[2];
  assign req_data = snap[3];
endmodule

// File: tb/tb_cfg_req_engine.sv
module tb_cfg_req_engine;
  localparam int TMO = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_hdr0, req_hdr1, req_hdr2, req_data;
  logic        cpl_valid = 1'b0;
  logic [2:0]  cpl_status = '0;
  logic [31:0] cpl_data = '0;

  int checks = 0;
  int fails  = 0;
  bit started = 1'b0;

  always #10 clk = ~clk;

  cfg_req_engine #(.ADDR_W(12), .TIMEOUT_CYCLES(TMO)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_hdr0(req_hdr0), .req_hdr1(req_hdr1),
    .req_hdr2(req_hdr2), .req_data(req_data), .cpl_valid(cpl_valid),
    .cpl_status(cpl_status), .cpl_data(cpl_data)
  );

  // behavioural reference model
  logic [31:0] m_w [4];
  logic [31:0] m_o [4];
  logic        m_busy, m_pv, m_isrd;
  logic [2:0]  m_st;
  logic [31:0] m_rd, m_rdata;
  int          m_age;

  always @(posedge clk) begin
    logic [31:0] nxt;
    logic done;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_w[i] = 0; m_o[i] = 0; end
      m_busy = 0; m_pv = 0; m_isrd = 0; m_st = 0; m_rd = 0; m_rdata = 0; m_age = 0;
    end else begin
      case (reg_addr)
        12'h460: nxt = m_w[0];
        12'h464: nxt = m_w[1];
        12'h468: nxt = m_w[2];
        12'h470: nxt = m_w[3];
        12'h488: nxt = {24'd0, m_st, 4'd0, m_busy};
        12'h48C: nxt = m_rd;
        default: nxt = 0;
      endcase
      done = m_busy && !m_pv && cpl_valid;
      if (!m_busy && reg_we && reg_addr == 12'h488 && reg_wdata[0]) begin
        m_busy = 1; m_pv = 1; m_st = 0; m_age = 0;
        for (int i = 0; i < 4; i++) m_o[i] = m_w[i];
        m_isrd = (m_w[0][31:29] == 3'd0);
      end else if (m_busy) begin
        if (m_pv && req_ready) m_pv = 0;
        if (done) begin
          m_busy = 0; m_st = cpl_status;
          if (m_isrd && cpl_status == 0) m_rd = cpl_data;
        end else begin
          m_age++;
          if (m_age == TMO) begin m_busy = 0; m_pv = 0; m_st = 3'b111; end
        end
      end
      if (reg_we) begin
        if (reg_addr == 12'h460) m_w[0] = reg_wdata;
        if (reg_addr == 12'h464) m_w[1] = reg_wdata;
        if (reg_addr == 12'h468) m_w[2] = reg_wdata;
        if (reg_addr == 12'h470) m_w[3] = reg_wdata;
      end
      m_rdata = nxt;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(req_valid == m_pv, "R4 req_valid vs model", 32'(req_valid), 32'(m_pv));
      chk(req_hdr0 == m_o[0], "R3 hdr0 vs model", req_hdr0, m_o[0]);
      chk(req_hdr1 == m_o[1], "R3 hdr1 vs model", req_hdr1, m_o[1]);
      chk(req_hdr2 == m_o[2], "R3 hdr2 vs model", req_hdr2, m_o[2]);
      chk(req_data == m_o[3], "R3 data vs model", req_data, m_o[3]);
      chk(reg_rdata == m_rdata, "R2 reg_rdata vs model", reg_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_addr = a;
    @(negedge clk); chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic complete(input logic [2:0] st, input logic [31:0] d);
    @(negedge clk); cpl_valid = 1; cpl_status = st; cpl_data = d;
    @(negedge clk); cpl_valid = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    started = 1;
    // R1 reset state
    chk(req_valid == 0, "R1 req_valid after reset", 32'(req_valid), 0);
    rd_chk(12'h488, 32'h0, "R1 control word after reset");
    rd_chk(12'h460, 32'h0, "R1 header0 after reset");
    rd_chk(12'h48C, 32'h0, "R1 read data after reset");
    // R2 header storage
    wr(12'h460, 32'h0400_0001);
    wr(12'h464, 32'h0000_000C);
    wr(12'h468, 32'h2A2B_0010);
    wr(12'h470, 32'h0000_0000);
    rd_chk(12'h460, 32'h0400_0001, "R2 header0 readback");
    rd_chk(12'h464, 32'h0000_000C, "R2 header1 readback");
    rd_chk(12'h468, 32'h2A2B_0010, "R2 header2 readback");
    // R3/R4 read request held while not ready
    wr(12'h488, 32'h1);
    chk(req_valid == 1, "R3 request issued", 32'(req_valid), 1);
    chk(req_hdr2 == 32'h2A2B_0010, "R3 header2 on port", req_hdr2, 32'h2A2B_0010);
    repeat (3) @(negedge clk);
    chk(req_valid == 1, "R4 request held without ready", 32'(req_valid), 1);
    rd_chk(12'h488, 32'h1, "R3 go bit reads 1");
    wr(12'h460, 32'h4400_0001);
    wr(12'h488, 32'h1);
    chk(req_hdr0 == 32'h0400_0001, "R5 restart ignored, header kept", req_hdr0, 32'h0400_0001);
    wr(12'h460, 32'h0400_0001);
    @(negedge clk); req_ready = 1;
    @(negedge clk); req_ready = 0;
    chk(req_valid == 0, "R4 valid drops after accept", 32'(req_valid), 0);
    wr(12'h488, 32'h1);
    @(negedge clk);
    chk(req_valid == 0, "R5 no second request while pending", 32'(req_valid), 0);
    rd_chk(12'h488, 32'h1, "R5 control word unchanged");
    complete(3'd0, 32'hDEAD_BEEF);
    rd_chk(12'h488, 32'h0, "R6 go bit clears, status ok");
    rd_chk(12'h48C, 32'hDEAD_BEEF, "R7 read data captured");
    // write request: read data untouched
    wr(12'h460, 32'h4400_0001);
    wr(12'h470, 32'h00AB_0000);
    req_ready = 1;
    wr(12'h488, 32'h1);
    chk(req_data == 32'h00AB_0000, "R3 write payload on port", req_data, 32'h00AB_0000);
    complete(3'd0, 32'h1234_5678);
    req_ready = 0;
    rd_chk(12'h488, 32'h0, "R6 write completion");
    rd_chk(12'h48C, 32'hDEAD_BEEF, "R7 write completion leaves read data");
    // failed read
    wr(12'h460, 32'h0400_0001);
    req_ready = 1;
    wr(12'h488, 32'h1);
    complete(3'd1, 32'h0000_0055);
    rd_chk(12'h488, 32'h20, "R6 failure status latched");
    rd_chk(12'h48C, 32'hDEAD_BEEF, "R7 failed read leaves read data");
    // new start clears status, then timeout
    wr(12'h488, 32'h1);
    rd_chk(12'h488, 32'h1, "R3 status cleared by new start");
    req_ready = 0;
    repeat (TMO + 5) @(negedge clk);
    rd_chk(12'h488, 32'hE0, "R8 abort after timeout");
    // stray completion
    complete(3'd2, 32'h0000_0077);
    rd_chk(12'h488, 32'hE0, "R9 stray completion ignored (control)");
    rd_chk(12'h48C, 32'hDEAD_BEEF, "R9 stray completion ignored (data)");
    // read-only and go-clear writes
    wr(12'h48C, 32'h0);
    wr(12'h488, 32'h0);
    rd_chk(12'h48C, 32'hDEAD_BEEF, "R10 read data not writable");
    rd_chk(12'h488, 32'hE0, "R10 control write without go bit");
    // timeout while never accepted
    wr(12'h488, 32'h1);
    chk(req_valid == 1, "R3 request issued before timeout", 32'(req_valid), 1);
    repeat (TMO + 5) @(negedge clk);
    chk(req_valid == 0, "R8 valid dropped on timeout", 32'(req_valid), 0);
    rd_chk(12'h488, 32'hE0, "R8 abort status when never accepted");
    finish_run();
  end
endmodule